// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers maskable interrupt requests from on-chip peripherals (timer, serial, A/D) and from eight external pins. It assigns each request to an interrupt group and chooses one group to present to the CPU. Every group owns a control word with a 3-bit priority level, an enable bit and a sticky pending flag. Each clock, the block takes the enabled, pending, unmasked group with the numerically lowest level and registers it as a request with that level. The group's index goes into an acceptance register, which the CPU reads to learn which group it is serving.

Non-maskable sources do not pass through grouping or arbitration. These are an external NMI pin, a watchdog overflow and a system error. They drive a separate NMI output directly, and only the external pin is first passed through a two-flop synchronizer. External maskable pins also pass through a two-flop synchronizer, and then a rising-edge detector. Software reaches the group control words and the acceptance register through a simple word-addressed register port. Reads are combinational. Writes take effect at the clock edge.

Groups 0 to N_INT-1 belong to the internal sources in order. Groups N_INT to N_INT+N_EXT-1 belong to external pins 0 to N_EXT-1.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset, every group control word reads 0x70: level 7, enable 0, flag 0. The acceptance register reads 0x00, irq_req_o is 0, irq_lvl_o is 7 and nmi_o is 0.
- R2: A high level on wdt_ovf_i or sys_err_i makes nmi_o high one cycle later. nmi_pin_i reaches nmi_o three cycles later, after two synchronizer stages. None of these inputs affects irq_req_o.
- R3: A high level on int_src_i[i] sets the flag of group i at the next edge. The flag stays set after the source falls.
- R4: A rising edge on ext_pin_i[j] sets the flag of group N_INT+j at the third clock edge after the pin rises. A pin that stays high does not set the flag again once the flag has been cleared.
- R5: Writing a control word with bit 0 set clears that group's flag. Writing with bit 0 clear leaves the flag unchanged. A source set in the same cycle as a clear wins, so the flag stays 1.
- R6: A group competes only while its flag is 1, its enable is 1 and its level is not 7. With no competing group, irq_req_o is 0 and irq_lvl_o is 7.
- R7: Among competing groups, the one with the lowest level value wins, and irq_lvl_o carries that level.
- R8: Among competing groups with equal levels, the lowest group number wins.
- R9: irq_req_o and irq_lvl_o follow the registered group state one cycle later. irq_req_o therefore drops in the cycle after the last competing flag is cleared.
- R10: The acceptance register is at address N_GRP. Bits [3:0] hold the group number of the most recent winner, and that value is kept when no group competes. Bit 7 equals irq_req_o.
- R11: Control word layout is bit 0 flag (read, write-one-to-clear), bit 1 enable, bits [6:4] level. Bits 7 and [3:2] read 0 and ignore writes. Addresses above N_GRP read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| int_src_i | input | N_INT | Internal peripheral requests, level sensitive |
| ext_pin_i | input | N_EXT | External interrupt pins, asynchronous |
| nmi_pin_i | input | 1 | External non-maskable pin, asynchronous |
| wdt_ovf_i | input | 1 | Watchdog overflow |
| sys_err_i | input | 1 | System error |
| reg_addr_i | input | AW | Register word address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| irq_req_o | output | 1 | Maskable request to the CPU |
| irq_lvl_o | output | 3 | Level of the requesting group |
| nmi_o | output | 1 | Non-maskable request to the CPU |

## Verification
A source event and a software write-one-to-clear can hit the same group flag in the same cycle. That collision decides whether a request is lost. The bench provokes it by holding an internal source high across the edge on which the clear write lands. It then reads the control word and expects the flag still set. A second overlap is an arbitration change in the same cycle as the clear of the current winner: the request must stay up, carrying the next group's level, and must drop exactly one cycle after the last flag is cleared.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
  localparam int unsigned LVL_W      = 3;
  localparam int unsigned DATA_W     = 8;
  localparam logic [LVL_W-1:0] LVL_MASKED = 3'd7;
  localparam int unsigned BIT_FLAG   = 0;
  localparam int unsigned BIT_EN     = 1;
  localparam int unsigned LVL_LSB    = 4;
  localparam int unsigned BIT_VALID  = 7;

  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/nmi_fwd.sv
module nmi_fwd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_pin_i,
  input  logic wdt_ovf_i,
  input  logic sys_err_i,
  output logic nmi_o
);
  logic s1_q, s2_q, nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      s1_q  <= nmi_pin_i;
      s2_q  <= s1_q;
      nmi_q <= s2_q | wdt_ovf_i | sys_err_i;
    end
  end

  assign nmi_o = nmi_q;
endmodule

// File: rtl/grp_ctrl_regs.sv
module grp_ctrl_regs
  import grp_irq_pkg::*;
#(
  parameter int unsigned N_GRP = 11,
  parameter int unsigned AW    = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_GRP-1:0]         set_i,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [N_GRP-1:0]         flag_o,
  output logic [N_GRP-1:0]         en_o,
  output logic [N_GRP-1:0][LVL_W-1:0] lvl_o
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic hit;
    assign hit = we_i && (addr_i == AW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_o[g] <= 1'b0;
        en_o[g]   <= 1'b0;
        lvl_o[g]  <= LVL_MASKED;
      end else begin
        // set beats a simultaneous clear
        if (set_i[g])                          flag_o[g] <= 1'b1;
        else if (hit && wdata_i[BIT_FLAG])     flag_o[g] <= 1'b0;
        if (hit) begin
          en_o[g]  <= wdata_i[BIT_EN];
          lvl_o[g] <= wdata_i[LVL_LSB +: LVL_W];
        end
      end
    end
  end
endmodule

// File: rtl/grp_arbiter.sv
module grp_arbiter
  import grp_irq_pkg::*;
#(
  parameter int unsigned N_GRP = 11,
  parameter int unsigned GW    = 4
) (
  input  logic [N_GRP-1:0]            flag_i,
  input  logic [N_GRP-1:0]            en_i,
  input  logic [N_GRP-1:0][LVL_W-1:0] lvl_i,
  output logic                        win_vld_o,
  output logic [GW-1:0]               win_grp_o,
  output logic [LVL_W-1:0]            win_lvl_o
);
  always_comb begin
    win_vld_o = 1'b0;
    win_grp_o = '0;
    win_lvl_o = LVL_MASKED;
    // ascending scan with strict compare keeps lowest index on ties
    for (int g = 0; g < N_GRP; g++) begin
      if (flag_i[g] && en_i[g] && (lvl_i[g] != LVL_MASKED) &&
          (!win_vld_o || (lvl_i[g] < win_lvl_o))) begin
        win_vld_o = 1'b1;
        win_grp_o = GW'(g);
        win_lvl_o = lvl_i[g];
      end
    end
  end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import grp_irq_pkg::*;
#(
  parameter int unsigned N_INT = 3,
  parameter int unsigned N_EXT = 8,
  localparam int unsigned N_GRP = N_INT + N_EXT,
  localparam int unsigned GW    = $clog2(N_GRP),
  localparam int unsigned AW    = $clog2(N_GRP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_INT-1:0]  int_src_i,
  input  logic [N_EXT-1:0]  ext_pin_i,
  input  logic              nmi_pin_i,
  input  logic              wdt_ovf_i,
  input  logic              sys_err_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              irq_req_o,
  output logic [2:0]        irq_lvl_o,
  output logic              nmi_o
);
  logic [N_EXT-1:0]            ext_rise;
  logic [N_GRP-1:0]            grp_set;
  logic [N_GRP-1:0]            grp_flag;
  logic [N_GRP-1:0]            grp_en;
  logic [N_GRP-1:0][LVL_W-1:0] grp_lvl;
  logic                        win_vld;
  logic [GW-1:0]               win_grp;
  logic [LVL_W-1:0]            win_lvl;
  logic                        req_q;
  logic [LVL_W-1:0]            lvl_q;
  logic [GW-1:0]               acc_grp_q;

  for (genvar j = 0; j < N_EXT; j++) begin : g_ext
    irq_pin_sync u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (ext_pin_i[j]),
      .rise_o (ext_rise[j])
    );
  end

  assign grp_set = {ext_rise, int_src_i};

  grp_ctrl_regs #(.N_GRP(N_GRP), .AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (grp_set),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .flag_o  (grp_flag),
    .en_o    (grp_en),
    .lvl_o   (grp_lvl)
  );

  grp_arbiter #(.N_GRP(N_GRP), .GW(GW)) u_arb (
    .flag_i    (grp_flag),
    .en_i      (grp_en),
    .lvl_i     (grp_lvl),
    .win_vld_o (win_vld),
    .win_grp_o (win_grp),
    .win_lvl_o (win_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q     <= 1'b0;
      lvl_q     <= LVL_MASKED;
      acc_grp_q <= '0;
    end else begin
      req_q <= win_vld;
      lvl_q <= win_lvl;
      if (win_vld) acc_grp_q <= win_grp;
    end
  end

  nmi_fwd u_nmi (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nmi_pin_i (nmi_pin_i),
    .wdt_ovf_i (wdt_ovf_i),
    .sys_err_i (sys_err_i),
    .nmi_o     (nmi_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (int'(reg_addr_i) < N_GRP) begin
      reg_rdata_o[BIT_FLAG]              = grp_flag[reg_addr_i];
      reg_rdata_o[BIT_EN]                = grp_en[reg_addr_i];
      reg_rdata_o[LVL_LSB +: LVL_W]      = grp_lvl[reg_addr_i];
    end else if (int'(reg_addr_i) == N_GRP) begin
      reg_rdata_o[BIT_VALID]             = req_q;
      reg_rdata_o[GW-1:0]                = acc_grp_q;
    end
  end

  assign irq_req_o = req_q;
  assign irq_lvl_o = lvl_q;
endmodule

// File: rtl/grp_irq_ctrl_chk.sv
module grp_irq_ctrl_chk #(
  parameter int unsigned N_INT = 3,
  parameter int unsigned N_EXT = 8,
  localparam int unsigned N_GRP = N_INT + N_EXT,
  localparam int unsigned AW    = $clog2(N_GRP + 1)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_INT-1:0]        int_src_i,
  input logic                    wdt_ovf_i,
  input logic                    sys_err_i,
  input logic [AW-1:0]           reg_addr_i,
  input logic                    reg_we_i,
  input logic [7:0]              reg_wdata_i,
  input logic                    irq_req_o,
  input logic [2:0]              irq_lvl_o,
  input logic                    nmi_o,
  input logic [N_GRP-1:0]        grp_flag,
  input logic [N_GRP-1:0]        grp_en,
  input logic [N_GRP-1:0][2:0]   grp_lvl
);
  logic cand_any;
  always_comb begin
    cand_any = 1'b0;
    for (int g = 0; g < N_GRP; g++)
      if (grp_flag[g] && grp_en[g] && grp_lvl[g] != 3'd7) cand_any = 1'b1;
  end

  // R2
  nmi_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_ovf_i || sys_err_i) |=> nmi_o);

  // R6
  req_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_lvl_o != 3'd7));

  // R9
  req_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_any |=> irq_req_o);

  // R9
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cand_any |=> !irq_req_o);

  for (genvar i = 0; i < N_INT; i++) begin : g_int
    // R3
    src_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int_src_i[i] |=> grp_flag[i]);

    // R5
    w1c_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && reg_addr_i == AW'(i) && reg_wdata_i[0] && !int_src_i[i])
        |=> !grp_flag[i]);
  end
endmodule

bind grp_irq_ctrl grp_irq_ctrl_chk #(.N_INT(N_INT), .N_EXT(N_EXT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .int_src_i   (int_src_i),
  .wdt_ovf_i   (wdt_ovf_i),
  .sys_err_i   (sys_err_i),
  .reg_addr_i  (reg_addr_i),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_req_o   (irq_req_o),
  .irq_lvl_o   (irq_lvl_o),
  .nmi_o       (nmi_o),
  .grp_flag    (grp_flag),
  .grp_en      (grp_en),
  .grp_lvl     (grp_lvl)
);

// File: tb/grp_irq_ctrl_tb.sv
`timescale 1ns/1ps
module grp_irq_ctrl_tb;
  localparam int N_INT = 3;
  localparam int N_EXT = 8;
  localparam int AW    = 4;
  localparam logic [AW-1:0] ACC = 4'd11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_INT-1:0] int_src = '0;
  logic [N_EXT-1:0] ext_pin = '0;
  logic             nmi_pin = 1'b0, wdt = 1'b0, syserr = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic             we = 1'b0;
  logic [7:0]       wdata = '0;
  logic [7:0]       rdata;
  logic             irq_req, nmi;
  logic [2:0]       irq_lvl;

  always #5 clk = ~clk;

  grp_irq_ctrl #(.N_INT(N_INT), .N_EXT(N_EXT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .int_src_i(int_src), .ext_pin_i(ext_pin),
    .nmi_pin_i(nmi_pin), .wdt_ovf_i(wdt), .sys_err_i(syserr),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_req_o(irq_req), .irq_lvl_o(irq_lvl), .nmi_o(nmi)
  );

  typedef struct {
    int         kind;   // 0 rdata, 1 {req,lvl}, 2 nmi
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     chk_ev;
  int       n_chk = 0, n_fail = 0;
  bit       done = 0;

  // monitor: pops and compares when the driver signals a sample point
  always @(chk_ev) begin
    while (sb_q.size() > 0) begin
      sb_item_t it;
      logic [7:0] obs;
      it = sb_q.pop_front();
      case (it.kind)
        0:       obs = rdata;
        1:       obs = {4'b0, irq_req, irq_lvl};
        default: obs = {7'b0, nmi};
      endcase
      n_chk++;
      if (obs !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %02h exp %02h", it.tag, obs, it.exp);
      end
    end
  end

  task automatic push(int kind, logic [7:0] exp, string tag);
    sb_item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_rd(logic [AW-1:0] a, logic [7:0] exp, string tag);
    addr = a;
    #1;
    push(0, exp, tag);
  endtask

  task automatic chk_irq(logic r, logic [2:0] l, string tag);
    push(1, {4'b0, r, l}, tag);
  endtask

  task automatic chk_nmi(logic v, string tag);
    push(2, {7'b0, v}, tag);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic pulse_int(int i);
    int_src[i] = 1'b1;
    tick();
    int_src[i] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk_rd(0, 8'h70, "R1 grp0");
    chk_rd(10, 8'h70, "R1 grp10");
    chk_rd(ACC, 8'h00, "R1 acc");
    chk_irq(0, 3'd7, "R1 irq");
    chk_nmi(0, "R1 nmi");

    // R11 layout, ignored bits
    wr(10, 8'hDE);
    chk_rd(10, 8'h52, "R11 layout");
    chk_rd(12, 8'h00, "R11 out of range");

    // R3 internal set, sticky
    wr(1, 8'h22);
    pulse_int(1);
    chk_rd(1, 8'h23, "R3 sticky flag");
    chk_irq(0, 3'd7, "R9 one cycle latency");
    tick();
    chk_irq(1, 3'd2, "R9 request up");
    chk_rd(ACC, 8'h81, "R10 acc grp1");

    // R7 lower level wins
    wr(2, 8'h12);
    pulse_int(2);
    tick();
    chk_irq(1, 3'd1, "R7 lower level");
    chk_rd(ACC, 8'h82, "R7 acc grp2");

    // R8 tie to lower group number
    wr(0, 8'h12);
    pulse_int(0);
    tick();
    chk_irq(1, 3'd1, "R8 tie level");
    chk_rd(ACC, 8'h80, "R8 acc grp0");

    // R5 write-one-to-clear
    wr(0, 8'h13);
    chk_rd(0, 8'h12, "R5 w1c");
    tick();
    chk_rd(ACC, 8'h82, "R8 next winner");
    wr(2, 8'h12);
    chk_rd(2, 8'h13, "R5 write zero keeps flag");

    // R5 set and clear in same cycle
    int_src[2] = 1'b1;
    wr(2, 8'h13);
    int_src[2] = 1'b0;
    chk_rd(2, 8'h13, "R5 set wins");

    // R9 drop timing
    wr(2, 8'h13);
    wr(1, 8'h23);
    chk_irq(1, 3'd2, "R9 still up");
    tick();
    chk_irq(0, 3'd7, "R9 dropped");
    chk_rd(ACC, 8'h01, "R10 hold last group");

    // R6 masked level and disabled group
    wr(1, 8'h72);
    pulse_int(1);
    tick(2);
    chk_irq(0, 3'd7, "R6 level 7 masked");
    chk_rd(1, 8'h73, "R6 masked flag set");
    wr(0, 8'h00);
    pulse_int(0);
    tick(2);
    chk_irq(0, 3'd7, "R6 disabled");
    chk_rd(0, 8'h01, "R6 disabled flag set");
    wr(0, 8'h02);
    tick();
    chk_irq(1, 3'd0, "R6 enable late");
    chk_rd(ACC, 8'h80, "R10 acc grp0 lvl0");
    wr(0, 8'h03);
    wr(1, 8'h73);
    tick();
    chk_irq(0, 3'd7, "R6 cleared");

    // R4 external pin 3 -> group 6
    wr(6, 8'h42);
    ext_pin[3] = 1'b1;
    tick(2);
    chk_rd(6, 8'h42, "R4 sync delay");
    tick();
    chk_rd(6, 8'h43, "R4 flag on third edge");
    tick();
    chk_irq(1, 3'd4, "R4 request");
    chk_rd(ACC, 8'h86, "R4 acc grp6");
    wr(6, 8'h43);
    tick(2);
    chk_rd(6, 8'h42, "R4 steady high no reset");
    chk_irq(0, 3'd7, "R4 no request");
    ext_pin[3] = 1'b0;
    tick(3);
    ext_pin[3] = 1'b1;
    tick(3);
    chk_rd(6, 8'h43, "R4 second edge");
    wr(6, 8'h43);
    ext_pin[3] = 1'b0;

    // R2 non-maskable forwarding
    tick(3);
    chk_nmi(0, "R2 idle");
    wdt = 1'b1;
    tick();
    chk_nmi(1, "R2 wdt");
    chk_irq(0, 3'd7, "R2 no maskable req");
    wdt = 1'b0;
    tick();
    chk_nmi(0, "R2 wdt released");
    syserr = 1'b1;
    tick();
    chk_nmi(1, "R2 syserr");
    syserr = 1'b0;
    tick();
    chk_nmi(0, "R2 syserr released");
    nmi_pin = 1'b1;
    tick(2);
    chk_nmi(0, "R2 pin synced");
    tick();
    chk_nmi(1, "R2 pin");
    nmi_pin = 1'b0;
    tick(3);
    chk_nmi(0, "R2 pin released");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule